// File: doc/BRIEF.md
# Parallel-Word Square-Wave Oscillator

This block produces a square-wave drive signal as a stream of 8-sample words, one word per fabric clock, for an external 8:1 double-data-rate serializer to shift out at eight times the fabric rate. Bit 0 of each word is the earliest sample in time. The toggle can land on any of the eight sample slots in a word, so the edge resolution is one fast sample and not one fabric clock. With a 108 MHz fabric clock the samples are about 1.16 ns apart (864 MHz).

The half period is given in samples as an unsigned fixed-point number with 16 integer and 8 fractional bits. The fractional part is carried from one half cycle to the next. Each half cycle therefore lasts either the floor of the accumulated length or one sample more, and the long-run frequency keeps the full fractional resolution. The period input may change on every clock, for example when a loop filter updates it. It is sampled only in the word that contains an edge, so each half cycle has one consistent length.

Top module: `sqwave_word_dco`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next `word_o` is 0 and `edge_o` is 0, and the phase accumulator and the output level are cleared. As a result, the first word after release that is enabled is 8'hFF, with `edge_o` high.
- R2: While `enable` is low at a clock edge, the next `word_o` is 0 and `edge_o` is 0, and the phase restarts as in R1. The word computed in an enabled clock appears on the outputs one clock later.
- R3: Bit i of `word_o` is sample i, and bit 0 is the earliest. When an edge falls at position k, bits below k keep the old level and bits k through 7 take the new level. `edge_o` is high exactly for the words that contain an edge. A word without an edge repeats the last level of the previous word.
- R4: With the first edge at absolute sample 0, each following edge lies at the floor of the running sum of the half periods in effect, counted in samples.
- R5: `half_period` is sampled only in a word that contains an edge, and that value sets the length of the half cycle that follows. Changes between edges have no effect on the output.
- R6: A `half_period` below 8.0 (24'h000800) is treated as exactly 8.0. No word ever holds more than one edge.
- R7: `half_period` is unsigned 16.8 fixed point: bits 23:8 are whole samples and bits 7:0 are 1/256 sample. The fractional remainder carries across edges. For example, a value of 10.5 (24'h000A80) gives half cycles of 10 and 11 samples, and exactly 64 edges in the first 84 words after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (word rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the oscillator; low holds the output low and restarts the phase |
| half_period | input | 24 | Half period in samples, unsigned 16.8 fixed point |
| word_o | output | 8 | Eight output samples, bit 0 earliest |
| edge_o | output | 1 | High for a word that contains a level change |

## Verification
The oscillator runs with these half periods:
- An integer value, which checks edge placement without any fraction.
- 10.5, where the carried fraction alternates the half-cycle length between 10 and 11.
- Exactly 8.0, which puts an edge in every word.
- 3.0, which must behave exactly like 8.0.
- 100.25, which gives long stretches of words with no edge.

A further run changes the period on every clock. This shows whether the value is taken only in edge words or whenever it changes. Restarts through reset and through `enable` show whether the accumulator is cleared. Over the 10.5 run, the edge count shows whether the remainder is kept or dropped.

// File: rtl/sqdco_pkg.sv
// Shared sizing for the parallel-word square-wave oscillator.
// Assumes the word width is a power of two so the edge slot is a bit field.
package sqdco_pkg;
    localparam int LANES_DEF  = 8;
    localparam int INT_W_DEF  = 16;
    localparam int FRAC_W_DEF = 8;
    localparam int ACC_W_DEF  = INT_W_DEF + FRAC_W_DEF;
endpackage

// File: rtl/sqdco_period_clamp.sv
// Limits the requested half period to at least one full word of samples.
// This keeps every word to a single edge. Purely combinational.
module sqdco_period_clamp #(
    parameter int LANES  = sqdco_pkg::LANES_DEF,
    parameter int FRAC_W = sqdco_pkg::FRAC_W_DEF,
    parameter int ACC_W  = sqdco_pkg::ACC_W_DEF
) (
    input  logic [ACC_W-1:0] hp_in,
    output logic [ACC_W-1:0] hp_eff
);
    localparam logic [ACC_W-1:0] MIN_HP = ACC_W'(LANES) << FRAC_W;

    // Raise short requests to the one-word minimum (R6).
    always_comb begin
        hp_eff = (hp_in < MIN_HP) ? MIN_HP : hp_in;
    end
endmodule

// File: rtl/sqdco_phase_acc.sv
// Phase state of the oscillator.
// remain holds the distance, in fixed-point samples, from the start of the
// current word to the next edge. The current output level is held beside it.
// An edge lies in this word when remain is below one word. Its slot is the
// integer part of remain. Assumes hp_eff >= one word.
module sqdco_phase_acc #(
    parameter int LANES  = sqdco_pkg::LANES_DEF,
    parameter int FRAC_W = sqdco_pkg::FRAC_W_DEF,
    parameter int ACC_W  = sqdco_pkg::ACC_W_DEF,
    localparam int POS_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] hp_eff,
    output logic             edge_now,
    output logic [POS_W-1:0] edge_pos,
    output logic             level
);
    localparam logic [ACC_W-1:0] SPAN = ACC_W'(LANES) << FRAC_W;

    logic [ACC_W-1:0] remain;

    // Decode whether, and where, an edge falls inside the current word.
    always_comb begin
        edge_now = (remain < SPAN);
        edge_pos = remain[FRAC_W +: POS_W];
    end

    // Advance by one word; at an edge, take the new half period and flip the level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            remain <= '0;
            level  <= 1'b0;
        end else if (edge_now) begin
            remain <= remain - SPAN + hp_eff;
            level  <= ~level;
        end else begin
            remain <= remain - SPAN;
        end
    end

    // R6: after an edge the next edge can come no earlier in its word.
    a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_now) |=> (remain >= $past(remain)));

    // R5: between edges the distance shrinks by exactly one word.
    a_r5_no_midcycle_load: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !edge_now) |=> (remain == $past(remain) - SPAN));
endmodule

// File: rtl/sqdco_word_gen.sv
// Builds the sample word from the edge decision.
// Slots at and above the edge position take the inverted level; the rest
// keep the current level. Slot 0 is the earliest sample.
module sqdco_word_gen #(
    parameter int LANES  = sqdco_pkg::LANES_DEF,
    localparam int POS_W = $clog2(LANES)
) (
    input  logic             edge_now,
    input  logic [POS_W-1:0] edge_pos,
    input  logic             level,
    output logic [LANES-1:0] word
);
    // One selector per sample slot (R3).
    for (genvar i = 0; i < LANES; i++) begin : g_slot
        always_comb begin
            word[i] = (edge_now && (int'(edge_pos) <= i)) ? ~level : level;
        end
    end
endmodule

// File: rtl/sqwave_word_dco.sv
// Parallel-word square-wave oscillator, top level.
// Emits LANES time-ordered samples per clock for an external serializer.
// Outputs are registered, so a word appears one clock after the state
// that formed it. Synchronous active-low reset.
module sqwave_word_dco #(
    parameter int LANES  = sqdco_pkg::LANES_DEF,
    parameter int INT_W  = sqdco_pkg::INT_W_DEF,
    parameter int FRAC_W = sqdco_pkg::FRAC_W_DEF,
    localparam int ACC_W = INT_W + FRAC_W,
    localparam int POS_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] half_period,
    output logic [LANES-1:0] word_o,
    output logic             edge_o
);
    logic [ACC_W-1:0] hp_eff;
    logic             edge_now;
    logic [POS_W-1:0] edge_pos;
    logic             level;
    logic [LANES-1:0] word_nxt;
    logic             was_run;

    sqdco_period_clamp #(.LANES(LANES), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_clamp (
        .hp_in  (half_period),
        .hp_eff (hp_eff)
    );

    sqdco_phase_acc #(.LANES(LANES), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .hp_eff   (hp_eff),
        .edge_now (edge_now),
        .edge_pos (edge_pos),
        .level    (level)
    );

    sqdco_word_gen #(.LANES(LANES)) u_word (
        .edge_now (edge_now),
        .edge_pos (edge_pos),
        .level    (level),
        .word     (word_nxt)
    );

    // Register the word and strobe; force them low when stopped (R1, R2).
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            word_o <= '0;
            edge_o <= 1'b0;
        end else begin
            word_o <= word_nxt;
            edge_o <= edge_now;
        end
    end

    // Note whether the word now on the outputs came from a running clock.
    always_ff @(posedge clk) begin
        was_run <= rst_n && enable;
    end

    // R1: reset quiets the outputs on the next word.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && !edge_o));

    // R2: a disabled clock quiets the outputs on the next word.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (word_o == '0 && !edge_o));

    // R3: a word without an edge repeats the previous final level.
    a_r3_flat_word: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && $past(was_run) && !edge_o) |->
            (word_o == {LANES{$past(word_o[LANES-1])}}));

    // R3: a word with an edge ends on the opposite level.
    a_r3_edge_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && $past(was_run) && edge_o) |->
            (word_o[LANES-1] != $past(word_o[LANES-1])));
endmodule

// File: tb/sqwave_word_dco_tb.sv
// Bench: a behavioural model in absolute sample time, compared every clock.
module sqwave_word_dco_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [23:0] half_period = 24'h001000;
    logic [7:0]  word_o;
    logic        edge_o;

    int    n_checks = 0;
    int    n_fail = 0;
    int    edge_cnt = 0;
    bit    done = 1'b0;
    string cur_tag = "R1 reset";

    // model state
    logic [7:0] exp_word = 8'h00;
    logic       exp_edge = 1'b0;
    longint     t_next = 0;
    longint     w_idx = 0;
    bit         lvl = 1'b0;

    sqwave_word_dco u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .half_period (half_period),
        .word_o      (word_o),
        .edge_o      (edge_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual %s expected %s", cur_tag, what, act, exp);
        end
    endtask

    // Compare the last expectation, then apply new inputs and advance the model.
    task automatic step(input bit r, input bit e, input int hp, input string tag);
        @(negedge clk);
        if (edge_o === 1'b1) edge_cnt++;
        check((word_o === exp_word) && (edge_o === exp_edge), "word/edge",
              $sformatf("%h/%b", word_o, edge_o), $sformatf("%h/%b", exp_word, exp_edge));
        rst_n = r; enable = e; half_period = 24'(hp); cur_tag = tag;
        if (!r || !e) begin
            exp_word = 8'h00; exp_edge = 1'b0;
            t_next = 0; w_idx = 0; lvl = 1'b0;
        end else begin
            longint eidx;
            bit     here;
            eidx = t_next >>> 8;
            here = (eidx < 8*w_idx + 8);
            for (int i = 0; i < 8; i++) begin
                longint s;
                s = 8*w_idx + i;
                exp_word[i] = (here && s >= eidx) ? ~lvl : lvl;
            end
            exp_edge = here;
            if (here) begin
                lvl = ~lvl;
                t_next += (hp < 2048) ? 2048 : hp;
            end
            w_idx++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset holds outputs low
        for (int j = 0; j < 3; j++) step(0, 1, 24'h001400, "R1 reset");
        // R1: first word after release must be FF (cleared accumulator)
        for (int j = 0; j < 60; j++) step(1, 1, 24'h001400, "R1/R3/R4 integer 20");
        // R2: disable mid-run, then restart
        for (int j = 0; j < 4; j++) step(1, 0, 24'h001400, "R2 disabled");
        for (int j = 0; j < 30; j++) step(1, 1, 24'h001A40, "R2/R4 restart 26.25");
        // R7: 10.5 with exact edge count
        step(1, 0, 24'h000A80, "R7 restart");
        edge_cnt = 0;
        for (int j = 0; j < 85; j++) step(1, (j < 84), 24'h000A80, "R7 frac 10.5");
        check(edge_cnt == 64, "R7 edges in 84 words", $sformatf("%0d", edge_cnt), "64");
        // R6: exactly 8.0 gives an edge every word
        edge_cnt = 0;
        for (int j = 0; j < 21; j++) step(1, 1, 24'h000800, "R6 min 8.0");
        check(edge_cnt == 20, "R6 edges in 20 words at 8.0", $sformatf("%0d", edge_cnt), "20");
        // R6: 3.0 clamps to 8.0
        for (int j = 0; j < 20; j++) step(1, 1, 24'h000300, "R6 clamp 3.0");
        step(1, 1, 24'h000000, "R6 clamp 0");
        for (int j = 0; j < 20; j++) step(1, 1, 24'h000000, "R6 clamp 0");
        // R5: period changes every clock, only edge words take it
        for (int j = 0; j < 400; j++)
            step(1, 1, 2048 + ((j * 37) % 41) * 67, "R5 changing period");
        // R4: long half period with fraction
        for (int j = 0; j < 120; j++) step(1, 1, 24'h006440, "R4 long 100.25");
        // R1: reset mid-run, then release
        for (int j = 0; j < 2; j++) step(0, 1, 24'h000C00, "R1 reset mid-run");
        for (int j = 0; j < 30; j++) step(1, 1, 24'h000C00, "R1 after release 12");
        step(1, 1, 24'h000C00, "R4 tail");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule